// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns writes to a software-generated-interrupt register into per-CPU pending state. Up to eight CPUs can issue these writes. Each write names one interrupt number, a target filter and, for one filter, a target list. The block marks the interrupt pending on every CPU the filter selects. For each target and interrupt it also keeps a mask of the CPUs that sent it. If several CPUs send the same interrupt to one target, the target receives it once for each sender.

Delivery logic reads the state through a request port. It names a target CPU and an interrupt number. In the same cycle the block offers the lowest-numbered sender still recorded for that pair. When the offer is accepted, that sender's bit is cleared on the next clock edge. The pending bit drops only when the last sender bit is gone. Choosing list slots and priority belongs to the delivery logic.

Top module: `sgi_dispatch`

## Requirements
- R1: After a synchronous active-low reset, every pending bit and every sender bit is zero, and a request is answered with `offer_valid` low.
- R2: `rd_data` reads as zero at all times, whatever has been written.
- R3: A write takes the interrupt number from `wr_data[3:0]`, the target list from `wr_data[23:16]` (bit k selects CPU k) and the filter from `wr_data[25:24]`. Filter 0 targets the CPUs in the list.
- R4: Filter 1 targets every online CPU except the writer.
- R5: Filter 2 targets only the writer.
- R6: Filter 3 changes no pending bit and no sender bit.
- R7: A CPU k with k >= `online_cnt` is never targeted by filters 0 and 1, even when its list bit is set.
- R8: Each targeted CPU gets the interrupt marked pending, and bit `wr_cpu` of its sender mask for that interrupt is set. That bit lives at `src_mask[((cpu*NUM_SGIS)+sgi)*NUM_CPUS + sender]`, and the pending bit lives at `sgi_pend[cpu*NUM_SGIS+sgi]`. The new state is visible one clock edge after the write.
- R9: While `dlv_req` is high, the block answers in the same cycle. `offer_valid` shows whether the sender mask of (`dlv_cpu`, `dlv_sgi`) is non-zero. `offer_src` gives the lowest set sender bit in that mask.
- R10: When a valid offer is accepted, that sender bit is cleared at the next edge. The pending bit clears at that same edge only if the mask becomes empty. A request without acceptance changes nothing.
- R11: If a write sets the same sender bit that an acceptance clears in the same cycle, the bit stays set and the pending bit stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| wr_cpu | input | 3 | ID of the writing CPU |
| online_cnt | input | 4 | Number of online CPUs (0 to 8) |
| rd_data | output | 32 | Register read data (always zero) |
| dlv_req | input | 1 | Delivery request |
| dlv_cpu | input | 3 | Target CPU being served |
| dlv_sgi | input | 4 | Interrupt number being served |
| dlv_accept | input | 1 | Delivery logic takes the current offer |
| offer_valid | output | 1 | A sender is available for the requested pair |
| offer_src | output | 3 | ID of the offered sender |
| sgi_pend | output | NUM_CPUS*NUM_SGIS | Pending bit per target CPU and interrupt |
| src_mask | output | NUM_CPUS*NUM_SGIS*NUM_CPUS | Sender mask per target CPU and interrupt |

## Verification
The properties assume a few things about the inputs. `dlv_cpu` and `wr_cpu` are below `NUM_CPUS`, `dlv_sgi` is below `NUM_SGIS`, and a writer using filter 2 is itself online. Both the directed and the random stimulus draw CPU IDs only from 0 to 7 and interrupt numbers from 0 to 15, so they stay inside these assumptions. The random phase picks its writer from the online CPUs. It mixes all four filter values and lets writes and acceptances land on the same entry in one cycle, so the set-over-clear ordering is exercised often.

// File: rtl/sgi_pkg.sv
// Shared constants and types for the software-generated interrupt dispatcher.
// Assumes at most eight CPUs (3-bit sender IDs) and up to sixteen interrupt numbers.
package sgi_pkg;
    localparam int SRC_W    = 3;   // sender / CPU ID width
    localparam int SGI_W    = 4;   // interrupt number width
    localparam int ID_LSB   = 0;   // interrupt number field
    localparam int LIST_LSB = 16;  // target list field
    localparam int FLT_LSB  = 24;  // filter field

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Decodes a register write into a one-hot-per-CPU target vector and an interrupt number.
// Assumes wr_cpu < NUM_CPUS; purely combinational.
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8
) (
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    input  logic [SRC_W-1:0]    wr_cpu,
    input  logic [SRC_W:0]      online_cnt,
    output logic [NUM_CPUS-1:0] tgt,
    output logic [SGI_W-1:0]    sgi_id
);
    logic [NUM_CPUS-1:0] online_m;
    logic [NUM_CPUS-1:0] self_m;
    logic [NUM_CPUS-1:0] list_m;
    sgi_filter_e         flt;

    // Build the online and requester masks.
    always_comb begin
        for (int i = 0; i < NUM_CPUS; i++) begin
            online_m[i] = (int'(online_cnt) > i);
            self_m[i]   = (int'(wr_cpu) == i);
        end
    end

    // Pull the fields out of the write data.
    always_comb begin
        list_m = wr_data[LIST_LSB +: NUM_CPUS];
        flt    = sgi_filter_e'(wr_data[FLT_LSB +: 2]);
        sgi_id = wr_data[ID_LSB +: SGI_W];
    end

    // Pick targets by filter; the reserved value selects nobody.
    always_comb begin
        tgt = '0;
        if (wr_en) begin
            case (flt)
                FLT_LIST:   tgt = list_m & online_m;
                FLT_OTHERS: tgt = online_m & ~self_m;
                FLT_SELF:   tgt = self_m;
                default:    tgt = '0;
            endcase
        end
    end
endmodule

// File: rtl/sgi_src_entry.sv
// One target/interrupt entry: a sender mask plus its pending bit.
// Set has priority over clear for the same sender bit in the same cycle.
module sgi_src_entry #(
    parameter int NUM_CPUS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [NUM_CPUS-1:0] set_oh,
    input  logic                clr_en,
    input  logic [NUM_CPUS-1:0] clr_oh,
    output logic [NUM_CPUS-1:0] mask,
    output logic                pend
);
    logic [NUM_CPUS-1:0] mask_nxt;

    // Next mask: clear first, then OR in the new sender.
    always_comb begin
        mask_nxt = mask;
        if (clr_en) mask_nxt = mask_nxt & ~clr_oh;
        if (set_en) mask_nxt = mask_nxt | set_oh;
    end

    // Register the mask; pending rises on a set and falls once the mask empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            pend <= 1'b0;
        end else begin
            mask <= mask_nxt;
            if (set_en)
                pend <= 1'b1;
            else if (mask_nxt == '0)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sgi_offer_sel.sv
// Selects the sender mask of the requested entry and offers its lowest set sender.
// Assumes sel_cpu < NUM_CPUS and sel_sgi < NUM_SGIS; purely combinational.
module sgi_offer_sel
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGIS = 16,
    localparam int ENTRIES = NUM_CPUS * NUM_SGIS
) (
    input  logic [ENTRIES*NUM_CPUS-1:0] mask_flat,
    input  logic [SRC_W-1:0]            sel_cpu,
    input  logic [SGI_W-1:0]            sel_sgi,
    output logic                        valid,
    output logic [SRC_W-1:0]            src
);
    logic [NUM_CPUS-1:0] sel_mask;

    // Multiplex the requested entry's mask.
    always_comb begin
        sel_mask = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int s = 0; s < NUM_SGIS; s++) begin
                if (int'(sel_cpu) == c && int'(sel_sgi) == s)
                    sel_mask = mask_flat[(c*NUM_SGIS+s)*NUM_CPUS +: NUM_CPUS];
            end
        end
    end

    // Priority-encode the lowest set sender.
    always_comb begin
        valid = |sel_mask;
        src   = '0;
        for (int i = NUM_CPUS - 1; i >= 0; i--) begin
            if (sel_mask[i]) src = SRC_W'(i);
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Software-generated interrupt dispatcher top.
// Decodes writes into per-target pending bits and sender masks, and serves one
// sender per delivery request. Assumes NUM_CPUS <= 8 and NUM_SGIS <= 16.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGIS = 16,
    localparam int ENTRIES = NUM_CPUS * NUM_SGIS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [31:0]                 wr_data,
    input  logic [SRC_W-1:0]            wr_cpu,
    input  logic [SRC_W:0]              online_cnt,
    output logic [31:0]                 rd_data,
    input  logic                        dlv_req,
    input  logic [SRC_W-1:0]            dlv_cpu,
    input  logic [SGI_W-1:0]            dlv_sgi,
    input  logic                        dlv_accept,
    output logic                        offer_valid,
    output logic [SRC_W-1:0]            offer_src,
    output logic [ENTRIES-1:0]          sgi_pend,
    output logic [ENTRIES*NUM_CPUS-1:0] src_mask
);
    logic [NUM_CPUS-1:0] tgt;
    logic [SGI_W-1:0]    sgi_id;
    logic [NUM_CPUS-1:0] wr_oh;
    logic [NUM_CPUS-1:0] acc_oh;
    logic                take;

    // The register has no readable content.
    assign rd_data = '0;

    sgi_target_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_cpu     (wr_cpu),
        .online_cnt (online_cnt),
        .tgt        (tgt),
        .sgi_id     (sgi_id)
    );

    sgi_offer_sel #(.NUM_CPUS(NUM_CPUS), .NUM_SGIS(NUM_SGIS)) u_sel (
        .mask_flat (src_mask),
        .sel_cpu   (dlv_cpu),
        .sel_sgi   (dlv_sgi),
        .valid     (offer_valid),
        .src       (offer_src)
    );

    // One-hot forms of the writer and of the accepted sender.
    always_comb begin
        wr_oh  = NUM_CPUS'(1) << wr_cpu;
        acc_oh = NUM_CPUS'(1) << offer_src;
        take   = dlv_req && dlv_accept && offer_valid;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SGIS; s++) begin : g_sgi
            logic set_hit;
            logic clr_hit;

            // Route the write and the acceptance to this entry.
            always_comb begin
                set_hit = tgt[c] && (int'(sgi_id) == s);
                clr_hit = take && (int'(dlv_cpu) == c) && (int'(dlv_sgi) == s);
            end

            sgi_src_entry #(.NUM_CPUS(NUM_CPUS)) u_ent (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_en (set_hit),
                .set_oh (wr_oh),
                .clr_en (clr_hit),
                .clr_oh (acc_oh),
                .mask   (src_mask[(c*NUM_SGIS+s)*NUM_CPUS +: NUM_CPUS]),
                .pend   (sgi_pend[c*NUM_SGIS+s])
            );
        end
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
// Property checker for sgi_dispatch, bound to every instance of it.
// Assumes CPU IDs below NUM_CPUS and interrupt numbers below NUM_SGIS.
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGIS = 16,
    localparam int ENTRIES = NUM_CPUS * NUM_SGIS
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [31:0]                 wr_data,
    input logic [SRC_W-1:0]            wr_cpu,
    input logic [SRC_W:0]              online_cnt,
    input logic                        dlv_req,
    input logic [SRC_W-1:0]            dlv_cpu,
    input logic [SGI_W-1:0]            dlv_sgi,
    input logic                        dlv_accept,
    input logic                        offer_valid,
    input logic [SRC_W-1:0]            offer_src,
    input logic [ENTRIES-1:0]          sgi_pend,
    input logic [ENTRIES*NUM_CPUS-1:0] src_mask
);
    logic [NUM_CPUS-1:0] sel_mask;
    logic [NUM_CPUS-1:0] below_m;
    logic [ENTRIES-1:0]  any_src;
    int                  acc_bit;
    int                  self_bit;
    logic                rsvd_wr;
    logic                accepting;

    // Observation helpers derived from the ports.
    always_comb begin
        for (int b = 0; b < NUM_CPUS; b++) begin
            sel_mask[b] = src_mask[(int'(dlv_cpu)*NUM_SGIS + int'(dlv_sgi))*NUM_CPUS + b];
            below_m[b]  = (b < int'(offer_src));
        end
        for (int e = 0; e < ENTRIES; e++)
            any_src[e] = |src_mask[e*NUM_CPUS +: NUM_CPUS];
        acc_bit   = (int'(dlv_cpu)*NUM_SGIS + int'(dlv_sgi))*NUM_CPUS + int'(offer_src);
        self_bit  = (int'(wr_cpu)*NUM_SGIS + int'(wr_data[SGI_W-1:0]))*NUM_CPUS + int'(wr_cpu);
        rsvd_wr   = wr_en && (wr_data[FLT_LSB +: 2] == 2'd3);
        accepting = dlv_req && dlv_accept && offer_valid;
    end

    p_offer_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && offer_valid) |-> (sel_mask[offer_src] && ((sel_mask & below_m) == '0)));

    p_offer_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && !offer_valid) |-> (sel_mask == '0));

    p_pend_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sgi_pend == any_src);

    p_accept_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accepting && !wr_en) |=> !src_mask[$past(acc_bit)]);

    p_rsvd_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsvd_wr && !(dlv_req && dlv_accept)) |=> ($stable(src_mask) && $stable(sgi_pend)));

    p_self_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[FLT_LSB +: 2] == 2'd2 && int'(wr_cpu) < int'(online_cnt)
         && int'(wr_data[SGI_W-1:0]) < NUM_SGIS) |=> src_mask[$past(self_bit)]);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS), .NUM_SGIS(NUM_SGIS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .wr_cpu      (wr_cpu),
    .online_cnt  (online_cnt),
    .dlv_req     (dlv_req),
    .dlv_cpu     (dlv_cpu),
    .dlv_sgi     (dlv_sgi),
    .dlv_accept  (dlv_accept),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .sgi_pend    (sgi_pend),
    .src_mask    (src_mask)
);

// File: tb/sim_sgi_dispatch.sv
// Bench for sgi_dispatch: a behavioural reference model compared on every clock.
module sim_sgi_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int NS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [2:0]        wr_cpu = '0;
    logic [3:0]        online_cnt = 4'd8;
    logic [31:0]       rd_data;
    logic              dlv_req = 1'b0;
    logic [2:0]        dlv_cpu = '0;
    logic [3:0]        dlv_sgi = '0;
    logic              dlv_accept = 1'b0;
    logic              offer_valid;
    logic [2:0]        offer_src;
    logic [NC*NS-1:0]  sgi_pend;
    logic [NC*NS*NC-1:0] src_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state.
    bit [7:0] m_mask [NC][NS];
    bit       m_pend [NC][NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_dispatch #(.NUM_CPUS(NC), .NUM_SGIS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_cpu(wr_cpu),
        .online_cnt(online_cnt), .rd_data(rd_data), .dlv_req(dlv_req), .dlv_cpu(dlv_cpu),
        .dlv_sgi(dlv_sgi), .dlv_accept(dlv_accept), .offer_valid(offer_valid),
        .offer_src(offer_src), .sgi_pend(sgi_pend), .src_mask(src_mask)
    );

    function automatic logic [31:0] mkw(input int flt, input logic [7:0] list, input int id);
        return {6'b0, 2'(flt), list, 12'b0, 4'(id)};
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare whole pending and sender state against the model.
    task automatic chk_state(input string tag);
        logic [NC*NS-1:0]    ep;
        logic [NC*NS*NC-1:0] em;
        int bad_e;
        bad_e = -1;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) begin
                ep[c*NS+s] = m_pend[c][s];
                em[(c*NS+s)*NC +: NC] = m_mask[c][s];
            end
        for (int e = 0; e < NC*NS; e++)
            if (bad_e < 0 && (em[e*NC +: NC] != src_mask[e*NC +: NC] || ep[e] != sgi_pend[e]))
                bad_e = e;
        n_chk++;
        if (bad_e >= 0) begin
            n_bad++;
            $display("FAIL %s entry %0d mask/pend actual=%0h/%0b expected=%0h/%0b", tag, bad_e,
                     src_mask[bad_e*NC +: NC], sgi_pend[bad_e], em[bad_e*NC +: NC], ep[bad_e]);
        end
    endtask

    // Drive one cycle at the falling edge, check the same-cycle offer, advance the model.
    task automatic step(input bit we, input logic [31:0] wd, input int wc, input int oc,
                        input bit dr, input int dc, input int ds, input bit da, input string tag);
        bit   ev;
        int   es;
        bit [7:0] tg;
        int   flt;
        wr_en = we; wr_data = wd; wr_cpu = 3'(wc); online_cnt = 4'(oc);
        dlv_req = dr; dlv_cpu = 3'(dc); dlv_sgi = 4'(ds); dlv_accept = da;
        #1;
        ev = (m_mask[dc][ds] != 0);
        es = 0;
        for (int i = NC - 1; i >= 0; i--) if (m_mask[dc][ds][i]) es = i;
        chk("R2", "rd_data", rd_data, 0);
        if (dr) begin
            chk(tag, "offer_valid", offer_valid, ev);
            if (ev) chk(tag, "offer_src", offer_src, es);
        end
        // Model: clear, then set.
        if (dr && da && ev) m_mask[dc][ds][es] = 0;
        tg = '0;
        flt = int'(wd[25:24]);
        if (we) begin
            for (int i = 0; i < NC; i++) begin
                if (flt == 0 && wd[16+i] && i < oc) tg[i] = 1;
                if (flt == 1 && i < oc && i != wc) tg[i] = 1;
                if (flt == 2 && i == wc) tg[i] = 1;
            end
        end
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) begin
                if (tg[c] && s == int'(wd[3:0])) begin
                    m_mask[c][s][wc] = 1;
                    m_pend[c][s] = 1;
                end else if (m_mask[c][s] == 0) m_pend[c][s] = 0;
            end
        @(posedge clk);
        @(negedge clk);
        chk_state(tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 8, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) begin m_mask[c][s] = 0; m_pend[c][s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, and an empty request offers nothing.
        step(0, '0, 0, 8, 1, 3, 7, 1, "R1");
        // R3: filter 0, list CPUs 1 and 2, interrupt 5 from CPU 0.
        step(1, mkw(0, 8'h06, 5), 0, 8, 0, 0, 0, 0, "R3");
        // R4: filter 1 from CPU 2 with four CPUs online.
        step(1, mkw(1, 8'h00, 9), 2, 4, 0, 0, 0, 0, "R4");
        // R5: filter 2 from CPU 7.
        step(1, mkw(2, 8'h00, 15), 7, 8, 0, 0, 0, 0, "R5");
        // R6: reserved filter with a full list.
        step(1, mkw(3, 8'hFF, 2), 1, 8, 0, 0, 0, 0, "R6");
        idle("R6");
        // R7: full list, only three CPUs online.
        step(1, mkw(0, 8'hFF, 1), 1, 3, 0, 0, 0, 0, "R7");
        // R8: interrupt 3 to CPU 4 from senders 6, 0, 5.
        step(1, mkw(0, 8'h10, 3), 6, 8, 0, 0, 0, 0, "R8");
        step(1, mkw(0, 8'h10, 3), 0, 8, 0, 0, 0, 0, "R8");
        step(1, mkw(0, 8'h10, 3), 5, 8, 0, 0, 0, 0, "R8");
        // R9: request without acceptance leaves state alone.
        step(0, '0, 0, 8, 1, 4, 3, 0, "R9");
        step(0, '0, 0, 8, 1, 4, 3, 0, "R9");
        // R10: accept sender 0, then 5; pending stays.
        step(0, '0, 0, 8, 1, 4, 3, 1, "R10");
        step(0, '0, 0, 8, 1, 4, 3, 1, "R10");
        // R11: accept sender 6 while CPU 6 resends the same interrupt.
        step(1, mkw(0, 8'h10, 3), 6, 8, 1, 4, 3, 1, "R11");
        // R10: final sender retires, pending drops.
        step(0, '0, 0, 8, 1, 4, 3, 1, "R10");
        step(0, '0, 0, 8, 1, 4, 3, 0, "R10");
        // Drain entries from the earlier directed writes.
        step(0, '0, 0, 8, 1, 1, 5, 1, "R10");
        step(0, '0, 0, 8, 1, 7, 15, 1, "R10");
        // Random mix of writes and deliveries on a small set of entries.
        for (int k = 0; k < 2000; k++) begin
            int oc;
            int wc;
            oc = 1 + int'($urandom_range(7));
            wc = int'($urandom_range(oc - 1));
            step(bit'($urandom_range(1)), mkw(int'($urandom_range(3)), 8'($urandom), int'($urandom_range(3))),
                 wc, oc, bit'($urandom_range(1)), int'($urandom_range(7)), int'($urandom_range(3)),
                 bit'($urandom_range(1)), "R8");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule